// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block watches a small set of already-filtered GPIO input lines and, for each line, turns selected input activity into two sticky flags: an interrupt flag and a wake flag. Each line has its own control word. The control word chooses edge or level sensing and the active polarity, with one code for sensing both edges. It also holds separate bits that allow the interrupt flag to latch and that allow the flag to reach the interrupt output. Three more bits allow a wake flag for each of three low-power states. A power-state input picks which of those three wake bits applies at any moment.

The same control word holds the output-enable and output-value bits that drive the pad, and a wake-Z bit that is stored but has no effect here. A line is reported as pending when either of its flags is set. Software writes a whole control word to one line per cycle. In the same write it can clear either flag with a write-1-to-clear bit. Software reads back the control word, the sampled input level and both flags through a combinational read port. Summing flags across lines and decoding bus addresses are left to the logic around this block.

Top module: `pin_event_unit`

## Requirements
- R1: With the trigger bit (word bit 0) at 0, the active-level field (bits 2:1) selects the edge: code 0 latches the interrupt flag on a rising edge and code 1 on a falling edge. An edge is the change between the input sampled at the previous clock and the current input, and the flag is visible one clock later.
- R2: With the trigger bit at 1, code 0 latches the flag whenever the input is high and code 1 whenever the input is low.
- R3: Code 2 latches on either edge in edge mode and never in level mode. Code 3 never latches in either mode.
- R4: Writing 1 to write bit 11 clears the interrupt flag at that edge. If a qualifying event occurs in the same cycle, the event wins and the flag stays set.
- R5: The interrupt output of a line is high exactly when its flag is set and its mask bit (bit 4) is 1. Clearing the mask blocks delivery but keeps the flag.
- R6: While the enable bit (bit 3) is 0, the flag reads 0 and events are ignored. A write that clears the enable bit also clears a set flag at that same edge.
- R7: In level mode, a clear issued while the input is still at its active level leaves the flag set.
- R8: The wake flag latches on a qualifying event when the wake bit chosen by the power state is 1. Power state 0, 1 and 2 choose bits 5, 6 and 7. Power state 3 chooses none. The wake flag does not depend on the interrupt enable.
- R9: Writing 1 to write bit 12 clears the wake flag. The pending output of a line is high when either of its flags is set.
- R10: The output-enable bit (bit 9) drives the pin direction output and the output-value bit (bit 10) drives the pin value output of that line only.
- R11: The read word returns the stored control bits 10:0, the interrupt flag at bit 11, the wake flag at bit 12, and the input level sampled at the last clock at bit 13.
- R12: After reset, every control bit and flag is 0 and all interrupt, wake, pending and direction outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | PINS | Filtered input level per line |
| pwr_state | input | 2 | Current power state (0, 1, 2 low-power; 3 running) |
| wr_en | input | 1 | Write strobe for one control word |
| wr_sel | input | SEL_W | Line addressed by the write |
| wr_data | input | 13 | Control bits 10:0, clear-interrupt bit 11, clear-wake bit 12 |
| rd_sel | input | SEL_W | Line addressed by the read |
| rd_data | output | 14 | Control word, flags and sampled input of the selected line |
| irq_out | output | PINS | Delivered interrupt per line |
| wake_out | output | PINS | Wake flag per line |
| pend_out | output | PINS | Interrupt or wake flag set per line |
| pin_oe | output | PINS | Output-enable per line |
| pin_out | output | PINS | Output value per line |

## Verification
Two functions can land on the same clock edge: a software clear of a flag and a fresh qualifying event on the same line. The bench provokes this in two ways. It drives an edge on the input in the very cycle it writes the clear bit. It also clears a level-mode line while the input stays active. The flag must remain set in both cases. A second collision occurs when the enable bit is written in the same cycle the input changes. The bench relies on this to sweep every trigger mode, polarity code and input transition with exactly one latching edge, and checks that the enable value being written governs the result.

// File: rtl/pin_evt_pkg.sv
// Shared types and field positions for the pin event detector.
// Assumes a fixed 11-bit control word; flags and the sampled level sit above it.
package pin_evt_pkg;

    localparam int CFG_W      = 11;
    localparam int WR_W       = 13;
    localparam int RD_W       = 14;
    localparam int CLR_INT_B  = 11;
    localparam int CLR_WAKE_B = 12;
    localparam int WAKE_STATES = 3;

    typedef enum logic [1:0] {
        ACT_HIGH = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_BOTH = 2'd2,
        ACT_NONE = 2'd3
    } act_e;

    // Bit 10 down to bit 0
    typedef struct packed {
        logic                   out_val;
        logic                   out_en;
        logic                   wake_z;
        logic [WAKE_STATES-1:0] wake_en;
        logic                   int_mask;
        logic                   int_en;
        act_e                   act;
        logic                   trig_lvl;
    } cfg_t;

endpackage

// File: rtl/pin_evt_trigger.sv
// Event decoder for one line: samples the input once per clock and turns
// the current/previous pair into a single-cycle qualifying event.
// Assumes pin_i is already synchronized and filtered.
module pin_evt_trigger
    import pin_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic trig_lvl,
    input  act_e act,
    output logic evt,
    output logic pin_q
);

    // Keep the previous sample for edge detection and for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_i;
    end

    // Decode sense mode and polarity into the event strobe.
    always_comb begin
        evt = 1'b0;
        if (trig_lvl) begin
            case (act)
                ACT_HIGH: evt = pin_i;
                ACT_LOW:  evt = !pin_i;
                default:  evt = 1'b0;
            endcase
        end else begin
            case (act)
                ACT_HIGH: evt = pin_i && !pin_q;
                ACT_LOW:  evt = !pin_i && pin_q;
                ACT_BOTH: evt = pin_i ^ pin_q;
                default:  evt = 1'b0;
            endcase
        end
    end

    AST_NO_EVT_INVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((act == ACT_NONE) || (trig_lvl && act == ACT_BOTH)) |-> !evt); // R3

endmodule

// File: rtl/pin_evt_status.sv
// Sticky interrupt and wake flags for one line.
// Assumes en_eff already reflects a write landing this cycle; events beat clears.
module pin_evt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic en_eff,
    input  logic evt,
    input  logic wake_ok,
    input  logic clr_int,
    input  logic clr_wake,
    output logic int_sts,
    output logic wake_sts
);

    // Interrupt flag: dropped while disabled, otherwise hold/clear, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       int_sts <= 1'b0;
        else if (!en_eff) int_sts <= 1'b0;
        else              int_sts <= (int_sts && !clr_int) || evt;
    end

    // Wake flag: latched by events allowed in the current power state.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_sts <= 1'b0;
        else        wake_sts <= (wake_sts && !clr_wake) || (evt && wake_ok);
    end

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> !int_sts); // R6
    AST_INT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_sts) |-> $past(evt)); // R1
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !evt) |=> !int_sts); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && evt) |=> int_sts); // R4
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_sts) |-> $past(evt && wake_ok)); // R8

endmodule

// File: rtl/pin_evt_slice.sv
// One line: control word register, event decoder and flag latches.
// Assumes at most one write per cycle; power state 3 allows no wake.
module pin_evt_slice
    import pin_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_i,
    input  logic [1:0]      pwr_state,
    input  logic            wr_hit,
    input  logic [WR_W-1:0] wr_data,
    output cfg_t            cfg_q,
    output logic            int_sts,
    output logic            wake_sts,
    output logic            pin_q
);

    cfg_t cfg_wr;
    logic evt;
    logic en_eff;
    logic wake_ok;

    assign cfg_wr = cfg_t'(wr_data[CFG_W-1:0]);

    // Store the control word on a write to this line.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_hit) cfg_q <= cfg_wr;
    end

    // The enable being written governs the same edge.
    assign en_eff = wr_hit ? cfg_wr.int_en : cfg_q.int_en;

    // Pick the wake enable for the present power state.
    always_comb begin
        wake_ok = 1'b0;
        for (int s = 0; s < WAKE_STATES; s++) begin
            if (pwr_state == 2'(s)) wake_ok = cfg_q.wake_en[s];
        end
    end

    pin_evt_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .trig_lvl (cfg_q.trig_lvl),
        .act      (cfg_q.act),
        .evt      (evt),
        .pin_q    (pin_q)
    );

    pin_evt_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_eff   (en_eff),
        .evt      (evt),
        .wake_ok  (wake_ok),
        .clr_int  (wr_hit && wr_data[CLR_INT_B]),
        .clr_wake (wr_hit && wr_data[CLR_WAKE_B]),
        .int_sts  (int_sts),
        .wake_sts (wake_sts)
    );

endmodule

// File: rtl/pin_event_unit.sv
// Top: PINS independent line slices, a write decoder and a read multiplexer.
// Assumes PINS >= 2; reads are combinational from registered state.
module pin_event_unit
    import pin_evt_pkg::*;
#(
    parameter int PINS  = 4,
    parameter int SEL_W = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PINS-1:0]  pin_in,
    input  logic [1:0]       pwr_state,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [RD_W-1:0]  rd_data,
    output logic [PINS-1:0]  irq_out,
    output logic [PINS-1:0]  wake_out,
    output logic [PINS-1:0]  pend_out,
    output logic [PINS-1:0]  pin_oe,
    output logic [PINS-1:0]  pin_out
);

    cfg_t            cfg_q [PINS];
    logic [PINS-1:0] int_sts;
    logic [PINS-1:0] wake_sts;
    logic [PINS-1:0] pin_q;

    for (genvar p = 0; p < PINS; p++) begin : g_line
        pin_evt_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pin_in[p]),
            .pwr_state (pwr_state),
            .wr_hit    (wr_en && (wr_sel == SEL_W'(p))),
            .wr_data   (wr_data),
            .cfg_q     (cfg_q[p]),
            .int_sts   (int_sts[p]),
            .wake_sts  (wake_sts[p]),
            .pin_q     (pin_q[p])
        );

        // Per-line outputs derived from the stored word and flags.
        assign irq_out[p]  = int_sts[p] && cfg_q[p].int_mask;
        assign wake_out[p] = wake_sts[p];
        assign pend_out[p] = int_sts[p] || wake_sts[p];
        assign pin_oe[p]   = cfg_q[p].out_en;
        assign pin_out[p]  = cfg_q[p].out_val;

        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_out[p]) |-> (int_sts[p] && pend_out[p])); // R5
    end

    // Assemble the read word for the selected line.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < PINS; p++) begin
            if (rd_sel == SEL_W'(p)) begin
                rd_data = {pin_q[p], wake_sts[p], int_sts[p], cfg_q[p]};
            end
        end
    end

endmodule

// File: tb/pin_event_unit_bench.sv
module pin_event_unit_bench;

    localparam int PINS = 4;
    localparam int SW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pin_in = '0;
    logic [1:0]      pwr_state = 2'd3;
    logic            wr_en = 1'b0;
    logic [SW-1:0]   wr_sel = '0;
    logic [12:0]     wr_data = '0;
    logic [SW-1:0]   rd_sel = '0;
    logic [13:0]     rd_data;
    logic [PINS-1:0] irq_out, wake_out, pend_out, pin_oe, pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pin_event_unit #(.PINS(PINS)) u_pin_event_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pwr_state(pwr_state),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_out(irq_out), .wake_out(wake_out),
        .pend_out(pend_out), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [12:0] mk(input logic trig, input logic [1:0] act,
        input logic en, input logic msk, input logic [2:0] wk,
        input logic oe, input logic ov, input logic ci, input logic cw);
        return {cw, ci, ov, oe, 1'b0, wk, msk, en, act, trig};
    endfunction

    task automatic chk(input logic [31:0] act_v, input logic [31:0] exp_v, input string req);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // Called at a negedge; the write lands at the next posedge.
    task automatic wr(input int line, input logic [12:0] d);
        wr_en = 1'b1; wr_sel = SW'(line); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic ex;
        logic [12:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R12: reset state
        for (int p = 0; p < PINS; p++) begin
            rd_sel = SW'(p);
            #1 chk(rd_data, 0, "R12 read word");
        end
        chk(irq_out | wake_out | pend_out | pin_oe, 0, "R12 outputs");

        // R1 R2 R3 R5 R11: sweep trigger, code, previous and current levels
        rd_sel = 0;
        for (int t = 0; t < 2; t++)
            for (int a = 0; a < 4; a++)
                for (int pv = 0; pv < 2; pv++)
                    for (int cv = 0; cv < 2; cv++) begin
                        pin_in[0] = pv[0];
                        wr(0, mk(t[0], a[1:0], 1'b0, 1'b0, 3'b0, 1'b0, 1'b0, 1'b1, 1'b1));
                        idle();
                        pin_in[0] = cv[0];
                        wr(0, mk(t[0], a[1:0], 1'b1, cv[0], 3'b0, 1'b0, 1'b0, 1'b0, 1'b0));
                        if (t == 1) ex = (a == 0) ? cv[0] : (a == 1) ? !cv[0] : 1'b0;
                        else ex = (a == 0) ? (!pv[0] && cv[0]) : (a == 1) ? (pv[0] && !cv[0]) :
                                  (a == 2) ? (pv[0] ^ cv[0]) : 1'b0;
                        chk(rd_data[11], ex, "R1 R2 R3 interrupt flag");
                        chk(irq_out[0], ex && cv[0], "R5 delivery");
                        chk(rd_data[13], cv[0], "R11 sampled input");
                    end

        // R6: events ignored while disabled
        pin_in[0] = 0;
        wr(0, mk(0, 2'd0, 0, 1, 3'b0, 0, 0, 1, 1));
        pin_in[0] = 1; idle();
        chk(rd_data[11], 0, "R6 disabled ignores edge");

        // R4: clear and event in the same cycle, then plain clear
        c = mk(0, 2'd0, 1, 1, 3'b0, 0, 0, 0, 0);
        pin_in[0] = 0; wr(0, c);
        pin_in[0] = 1; idle();
        chk(rd_data[11], 1, "R4 edge latched");
        pin_in[0] = 0; idle();
        pin_in[0] = 1; wr(0, c | 13'h0800);
        chk(rd_data[11], 1, "R4 event beats clear");
        wr(0, c | 13'h0800);
        chk(rd_data[11], 0, "R4 clear");

        // R5: mask off keeps the flag
        pin_in[0] = 0; idle(); pin_in[0] = 1; idle();
        wr(0, mk(0, 2'd0, 1, 0, 3'b0, 0, 0, 0, 0));
        chk(rd_data[11], 1, "R5 flag kept when masked");
        chk(irq_out[0], 0, "R5 masked delivery");
        // R6: disabling clears
        wr(0, mk(0, 2'd0, 0, 0, 3'b0, 0, 0, 0, 0));
        chk(rd_data[11], 0, "R6 disable clears");

        // R7: level mode re-asserts after clear
        c = mk(1, 2'd0, 1, 1, 3'b0, 0, 0, 0, 0);
        pin_in[0] = 1; wr(0, c); idle();
        wr(0, c | 13'h0800);
        chk(rd_data[11], 1, "R7 level flag persists");
        pin_in[0] = 0; wr(0, c | 13'h0800);
        chk(rd_data[11], 0, "R7 clear after inactive");

        // R8 R9: wake by power state
        for (int ps = 0; ps < 4; ps++)
            for (int k = 0; k < 3; k++) begin
                pwr_state = 2'(ps);
                pin_in[0] = 0;
                wr(0, mk(0, 2'd0, 0, 0, 3'(1 << k), 0, 0, 1, 1));
                pin_in[0] = 1; idle();
                chk(rd_data[12], ps == k, "R8 wake flag");
                chk(wake_out[0], ps == k, "R8 wake output");
                chk(pend_out[0], ps == k, "R9 pending");
                wr(0, mk(0, 2'd0, 0, 0, 3'(1 << k), 0, 0, 0, 1));
                chk(rd_data[12], 0, "R9 wake clear");
            end
        pwr_state = 3;

        // R10 R11: output bits per line and readback
        wr(1, mk(0, 2'd1, 0, 1, 3'b101, 1, 1, 0, 0));
        chk(pin_oe, 4'b0010, "R10 direction");
        chk(pin_out, 4'b0010, "R10 value");
        rd_sel = 1;
        #1 chk(rd_data[10:0], 11'h6B2, "R11 control readback");
        wr(1, mk(0, 2'd0, 0, 0, 3'b0, 0, 1, 0, 0));
        chk(pin_oe[1], 0, "R10 direction off");
        chk(pin_out[1], 1, "R10 value held");

        done = 1;
        finish_run();
    end

endmodule